// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate with Roll-Over Pulse

This block multiplies two operands and keeps a running sum of the products in a wrapping accumulator. A mode input chooses between two's complement and plain binary arithmetic. Operands may be narrower than the native multiplier width (9, 18 or 36 bits). The block widens them in its first register stage: with zeros in unsigned mode and with copies of the top bit in signed mode.

There are three register stages. The first captures the widened operands. The second holds the product. The third is the accumulator itself, together with a one-cycle roll-over flag. The accumulator wraps and never saturates. It is twice the native width plus a guard field. Counting the flag pulses outside the block lets a user build a wider total.

Each stage takes its clock enable from a bank of four enable inputs and its reset from a bank of four reset inputs. A per-stage parameter picks which source bit applies. A load input, carried down the pipeline with the operands, makes the accumulator take the product in place of the sum.

Top module: `mac_rollover`

## Requirements
- R1: A product whose operands are presented before a clock edge appears in `acc` after the third rising edge, counting that edge as the first, when all enables are high.
- R2: In unsigned mode (`is_signed`=0), an operand narrower than `OPW` is widened with zero upper bits. For example, 8-bit 0xFA counts as 250.
- R3: In signed mode (`is_signed`=1), an operand narrower than `OPW` is widened by copying its top bit. For example, 8-bit 0xFA counts as -6.
- R4: Without load, the accumulator becomes (accumulator + product) modulo 2^ACCW, where ACCW = 2*OPW+GUARD. It wraps rather than saturating.
- R5: In unsigned mode, `ovf` is high for the cycle in which the new accumulator value is smaller than the previous one.
- R6: In signed mode, `ovf` is high for the cycle in which the accumulator and the product share a sign and the new accumulator has the other sign.
- R7: `ovf` is high only in the cycle right after an enabled accumulate that rolled over. In every other cycle it is low.
- R8: When the load bit reaches the output stage, the accumulator takes the product and `ovf` stays low.
- R9: Each stage (input, product, output) updates only when the `ce` bit selected by its parameter is high, and holds otherwise. The unselected `ce` bits have no effect. The defaults select bits 0, 1 and 2.
- R10: Each stage clears synchronously whenever the `rst` bit selected by its parameter is high, whatever the enables. The unselected `rst` bits have no effect. The defaults select bits 0, 1 and 2.
- R11: In unsigned operation, the number of `ovf` pulses since a load, placed above the ACCW bits of `acc`, equals the exact sum of the products.
- R12: After reset, `acc` is zero and `ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| ce | input | 4 | Bank of clock enable sources |
| rst | input | 4 | Bank of synchronous active-high reset sources |
| a | input | INW | First operand |
| b | input | INW | Second operand |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| load | input | 1 | Replace the accumulator with this product |
| acc | output | ACCW | Accumulator |
| ovf | output | 1 | One-cycle roll-over flag |

## Verification
The bench drives the byte 0xFA in both modes. A design that widened with the wrong fill would give 36 where 62500 is expected, or the reverse. It pushes the accumulator across the unsigned top, across the positive signed limit and below the negative one. A detector that used the wrong rule for the mode, or that held the flag for longer than one cycle, then differs from the model. Loads, enables and resets are also toggled at random with the unused bank bits busy. A stage wired to the wrong source, or a pulse not blocked on load, shows up as an accumulator or flag mismatch.

// File: rtl/mac_rollover.sv
module mac_rollover #(
  parameter int OPW = 18,
  parameter int INW = OPW,
  parameter int GUARD = 4,
  parameter int CE_IN_SEL = 0,
  parameter int CE_MID_SEL = 1,
  parameter int CE_OUT_SEL = 2,
  parameter int RST_IN_SEL = 0,
  parameter int RST_MID_SEL = 1,
  parameter int RST_OUT_SEL = 2,
  localparam int ACCW = 2*OPW + GUARD
) (
  input  logic            clk,
  input  logic [3:0]      ce,
  input  logic [3:0]      rst,
  input  logic [INW-1:0]  a,
  input  logic [INW-1:0]  b,
  input  logic            is_signed,
  input  logic            load,
  output logic [ACCW-1:0] acc,
  output logic            ovf
);
  localparam int TOP = ACCW - 1;

  wire ce_i = ce[CE_IN_SEL];
  wire ce_m = ce[CE_MID_SEL];
  wire ce_o = ce[CE_OUT_SEL];
  wire rs_i = rst[RST_IN_SEL];
  wire rs_m = rst[RST_MID_SEL];
  wire rs_o = rst[RST_OUT_SEL];

  logic [OPW-1:0] a_q, b_q;
  logic sg_q, ld_q;

  always_ff @(posedge clk)
    if (rs_i) begin
      a_q <= '0; b_q <= '0; sg_q <= 1'b0; ld_q <= 1'b0;
    end else if (ce_i) begin
      a_q <= is_signed ? OPW'($signed(a)) : OPW'(a);
      b_q <= is_signed ? OPW'($signed(b)) : OPW'(b);
      sg_q <= is_signed;
      ld_q <= load;
    end

  logic signed [OPW:0] ax, bx;
  logic signed [2*OPW+1:0] pw;
  assign ax = {sg_q & a_q[OPW-1], a_q};
  assign bx = {sg_q & b_q[OPW-1], b_q};
  assign pw = ax * bx;

  logic [ACCW-1:0] prod_q;
  logic sg_p, ld_p;

  always_ff @(posedge clk)
    if (rs_m) begin
      prod_q <= '0; sg_p <= 1'b0; ld_p <= 1'b0;
    end else if (ce_m) begin
      prod_q <= ACCW'(pw);
      sg_p <= sg_q;
      ld_p <= ld_q;
    end

  logic [ACCW:0] usum;
  logic [ACCW-1:0] sum;
  logic s_ovf;
  assign usum  = {1'b0, acc} + {1'b0, prod_q};
  assign sum   = usum[ACCW-1:0];
  assign s_ovf = (acc[TOP] == prod_q[TOP]) && (sum[TOP] != acc[TOP]);

  always_ff @(posedge clk)
    if (rs_o) begin
      acc <= '0; ovf <= 1'b0;
    end else if (ce_o) begin
      acc <= ld_p ? prod_q : sum;
      ovf <= !ld_p && (sg_p ? s_ovf : usum[ACCW]);
    end else
      ovf <= 1'b0;

  assert_reset_clears_R10: assert property (@(posedge clk)
    rs_o |=> (acc == '0) && !ovf);

  assert_hold_when_disabled_R9: assert property (@(posedge clk) disable iff (rs_o)
    !ce_o |=> $stable(acc) && !ovf);

  assert_no_pulse_on_load_R8: assert property (@(posedge clk) disable iff (rs_o)
    (ce_o && ld_p) |=> !ovf && (acc == $past(prod_q)));

  assert_unsigned_wrap_R5: assert property (@(posedge clk) disable iff (rs_o)
    (ce_o && !ld_p && !sg_p) |=> (ovf == (acc < $past(acc))));

  assert_signed_wrap_R6: assert property (@(posedge clk) disable iff (rs_o)
    (ce_o && !ld_p && sg_p) |=>
      (ovf == (($past(acc[TOP]) == $past(prod_q[TOP])) && (acc[TOP] != $past(acc[TOP])))));
endmodule

// File: tb/mac_rollover_test.sv
`timescale 1ns/1ps
module mac_rollover_test;
  localparam int OPW = 9, INW = 8, GUARD = 2;
  localparam int ACCW = 2*OPW + GUARD;
  localparam longint M = longint'(1) << ACCW;

  logic clk = 0;
  logic [3:0] ce = 4'hF, rst = 4'hF;
  logic [INW-1:0] a = '0, b = '0;
  logic is_signed = 0, load = 0;
  logic [ACCW-1:0] acc;
  logic ovf;

  always #10 clk = ~clk;

  mac_rollover #(.OPW(OPW), .INW(INW), .GUARD(GUARD)) uut (
    .clk(clk), .ce(ce), .rst(rst), .a(a), .b(b),
    .is_signed(is_signed), .load(load), .acc(acc), .ovf(ovf));

  int checks = 0, fails = 0, pulses = 0;
  bit cmp_on = 0;
  string phase = "R12";

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint opval(input logic [INW-1:0] v, input logic sg);
    return sg ? longint'($signed(v)) : longint'(v);
  endfunction

  longint m_a, m_b, m_p, m_acc, pp, as_v, s_v;
  logic m_sg1, m_ld1, m_sg2, m_ld2, m_ovf;
  initial begin
    m_a = 0; m_b = 0; m_p = 0; m_acc = 0;
    m_sg1 = 0; m_ld1 = 0; m_sg2 = 0; m_ld2 = 0; m_ovf = 0;
  end

  always @(posedge clk) begin
    if (rst[2]) begin m_acc = 0; m_ovf = 0; end
    else if (ce[2]) begin
      pp = ((m_p % M) + M) % M;
      if (m_ld2) begin m_acc = pp; m_ovf = 0; end
      else begin
        if (m_sg2) begin
          as_v = (m_acc >= M/2) ? m_acc - M : m_acc;
          s_v = as_v + m_p;
          m_ovf = (s_v >= M/2) || (s_v < -(M/2));
        end else
          m_ovf = (m_acc + pp) >= M;
        m_acc = (m_acc + pp) % M;
      end
    end else m_ovf = 0;
    if (rst[1]) begin m_p = 0; m_sg2 = 0; m_ld2 = 0; end
    else if (ce[1]) begin m_p = m_a * m_b; m_sg2 = m_sg1; m_ld2 = m_ld1; end
    if (rst[0]) begin m_a = 0; m_b = 0; m_sg1 = 0; m_ld1 = 0; end
    else if (ce[0]) begin
      m_a = opval(a, is_signed); m_b = opval(b, is_signed);
      m_sg1 = is_signed; m_ld1 = load;
    end
  end

  always @(negedge clk) begin
    if (ovf === 1'b1) pulses++;
    if (cmp_on) begin
      chk({phase, " acc"}, longint'(acc), m_acc);
      chk({phase, " ovf R7"}, longint'(ovf), longint'(m_ovf));
    end
  end

  task automatic step(input logic [INW-1:0] va, input logic [INW-1:0] vb,
                      input logic sg, input logic ld);
    a = va; b = vb; is_signed = sg; load = ld;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 acc", longint'(acc), 0);
    chk("R12 ovf", longint'(ovf), 0);
    rst = 4'h0;

    a = 8'd3; b = 8'd5; is_signed = 0; load = 1;
    @(negedge clk);
    chk("R1 edge1", longint'(acc), 0);
    a = 0; b = 0; load = 0;
    @(negedge clk);
    chk("R1 edge2", longint'(acc), 0);
    @(negedge clk);
    chk("R1 edge3", longint'(acc), 15);
    cmp_on = 1;

    phase = "R2 R4 R5";
    pulses = 0;
    step(8'hFA, 8'hFA, 0, 1);
    for (int i = 0; i < 39; i++) step(8'hFA, 8'hFA, 0, 0);
    repeat (3) step(0, 0, 0, 0);
    chk("R11 wide sum", longint'(pulses) * M + longint'(acc), 40 * 62500);
    chk("R2 pulse count", longint'(pulses), 2);

    phase = "R3";
    step(8'hFA, 8'hFA, 1, 1);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R3 signed widen", longint'(acc), 36);
    phase = "R3 R6";
    for (int i = 0; i < 40; i++) step(8'h80, 8'h80, 1, 0);
    for (int i = 0; i < 70; i++) step(8'h80, 8'h7F, 1, 0);

    phase = "R8";
    for (int i = 0; i < 300; i++)
      step(INW'($urandom), INW'($urandom), 1'($urandom), ($urandom % 6) == 0);

    phase = "R9";
    for (int i = 0; i < 400; i++) begin
      ce = 4'($urandom);
      step(INW'($urandom), INW'($urandom), 1'($urandom), ($urandom % 10) == 0);
    end

    phase = "R10";
    for (int i = 0; i < 300; i++) begin
      ce = 4'($urandom);
      rst = (($urandom % 8) == 0) ? 4'($urandom) : {1'($urandom), 3'b000};
      step(INW'($urandom), INW'($urandom), 1'($urandom), ($urandom % 10) == 0);
    end
    ce = 4'h0; rst = 4'b0100;
    @(negedge clk);
    chk("R10 clear without enable", longint'(acc), 0);
    rst = 4'h0; ce = 4'hF;
    step(0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule